// File: doc/BRIEF.md
# Flash page-program write buffer

This block sits between a register bus and the serial lines of a NOR flash device. It holds one program page of 128 bytes, and software fills that page through a single 32-bit data port. When the command code for a buffered program arrives, the block sends a complete page-program frame to the flash and raises a busy flag until the last bit has gone out. The frame is the flash opcode, a 3- or 4-byte address and the 128 page bytes.

The same storage also serves as a read prefetch buffer. A mode request therefore moves it between prefetch use and program use. The granted mode is returned on a readback output, so software polls that output until it matches what it asked for before it loads data. The page address is built from four byte-wide registers, and one address-width control picks how many of them go out on the wire.

Top module: `pp_write_buffer`

## Requirements
- R1: After reset, `busy` is 0, `spi_cs_n` is 1, `spi_sck` is 0 and `mode_ack` is 0 (prefetch use).
- R2: A mode request (1 = page program, 0 = read prefetch) appears on `mode_ack` one clock after it is written while the block is idle. A request written while a program runs is held and is applied at the first idle clock after `busy` falls.
- R3: Each accepted data word fills four consecutive page bytes. Bits 7:0 hold the lowest-addressed byte and bits 31:24 hold the highest, so 32 words make the whole page.
- R4: The fill pointer returns to word 0 whenever `mode_ack` changes from 0 to 1. It wraps after 32 words, so a 33rd word overwrites word 0.
- R5: Data words are ignored while `mode_ack` is 0 and while `busy` is 1. The page contents stay as they were.
- R6: Command code 0x10 starts a program only when `mode_ack` is 1 and `busy` is 0. Any other code, or 0x10 in prefetch use, leaves `busy` at 0.
- R7: A program frame is opcode 0x02, then the address bytes most significant first, then page bytes 0 to 127. Every byte is sent MSB first in SPI mode 0, with one bit per two clocks and `spi_cs_n` low across the whole frame.
- R8: When `width_sel` is 1, four address bytes are sent. When it is 0, three are sent: address bytes 2, 1 and 0.
- R9: `addr_sel` 0 to 3 writes address byte 0 (least significant) to byte 3.
- R10: `busy` stays high for exactly 2 × frame-bits clocks (frame bits = 8 × (1 + address bytes + 128)). Then `busy` clears and `spi_cs_n` returns high.
- R11: The address and the address width are captured at the start of a program. Writes to them during the frame do not change the frame that is running.
- R12: A program issued with fewer than 32 words loaded still sends all 128 bytes. Unloaded words keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode request write strobe |
| mode_req | input | 1 | Requested buffer use: 1 program, 0 prefetch |
| mode_ack | output | 1 | Granted buffer use, read back by software |
| word_wr | input | 1 | Data word write strobe |
| word_data | input | 32 | Data word, byte 0 in bits 7:0 |
| addr_wr | input | 1 | Address byte write strobe |
| addr_sel | input | 2 | Address byte index, 0 = least significant |
| addr_data | input | 8 | Address byte value |
| width_wr | input | 1 | Address width write strobe |
| width_sel | input | 1 | 1 = 4-byte address, 0 = 3-byte address |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code; 0x10 starts a program |
| busy | output | 1 | Program frame in progress |
| spi_sck | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
Each frame is captured from the serial lines and compared bit by bit against a frame built from a bench model of the page, the address registers and the width. Full pages of random words are sent with both address widths, and each one shows whether byte lanes and address order come out in the right sequence. Partial fills, a 33-word overfill and fills after the mode is re-entered separate pointer reset and wrap from plain overwrite. Words written in prefetch use, and writes made during a frame, are followed by a program with no new data. Any change they made would then show up in the page bytes on the wire. Commands with the wrong code or in the wrong mode are checked against a `busy` that never rises.

// File: rtl/pp_wb_pkg.sv
package pp_wb_pkg;
    localparam logic [7:0] CMD_BUF_PROGRAM  = 8'h10;
    localparam logic [7:0] FLASH_OP_PROGRAM = 8'h02;
    localparam int         ADDR_REG_BYTES   = 4;
endpackage

// File: rtl/pp_page_store.sv
module pp_page_store #(
    parameter int PAGE_BYTES = 128,
    parameter int WORD_W     = 32,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int WORDS      = PAGE_BYTES / WORD_BYTES,
    localparam int PTR_W      = $clog2(WORDS),
    localparam int IDX_W      = $clog2(PAGE_BYTES),
    localparam int LANE_W     = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_ptr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte
);
    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             ptr;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.mem[s_q.ptr] = wr_word;
            s_d.ptr = s_q.ptr + PTR_W'(1);
        end
        if (clear_ptr) begin
            s_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [PTR_W-1:0]  rd_word_sel;
    logic [LANE_W-1:0] rd_lane;
    assign rd_word_sel = rd_idx[IDX_W-1:LANE_W];
    assign rd_lane     = rd_idx[LANE_W-1:0];
    assign rd_byte     = s_q.mem[rd_word_sel][rd_lane*8 +: 8];

    // R4: pointer restart on mode entry
    p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_ptr |=> (s_q.ptr == '0));
    // R4: one step per accepted word, wrapping at the page end
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear_ptr) |=> (s_q.ptr == PTR_W'($past(s_q.ptr) + 1)));
    // R5: no accepted word means page and pointer unchanged
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clear_ptr) |=> ($stable(s_q.ptr) && $stable(s_q.mem)));
endmodule

// File: rtl/pp_serial_seq.sv
module pp_serial_seq
    import pp_wb_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int MAX_BYTES = 1 + ADDR_REG_BYTES + PAGE_BYTES,
    localparam int CNT_W     = $clog2(MAX_BYTES * 8),
    localparam int BP_W      = CNT_W - 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [ADDR_REG_BYTES-1:0][7:0]    addr,
    input  logic                              wide,
    input  logic [7:0]                        rd_byte,
    output logic [IDX_W-1:0]                  rd_idx,
    output logic                              busy,
    output logic                              sck,
    output logic                              cs_n,
    output logic                              mosi
);
    typedef struct packed {
        logic                           busy;
        logic                           phase;
        logic [CNT_W-1:0]               cnt;
        logic [ADDR_REG_BYTES-1:0][7:0] addr;
        logic                           wide;
    } seq_t;

    seq_t s_d, s_q;

    logic [BP_W-1:0]  byte_pos;
    logic [BP_W-1:0]  hdr_bytes;
    logic [BP_W-1:0]  data_pos;
    logic [1:0]       addr_k;
    logic [CNT_W-1:0] last_bit;
    logic [7:0]       cur_byte;

    always_comb begin
        byte_pos  = s_q.cnt[CNT_W-1:3];
        hdr_bytes = s_q.wide ? BP_W'(5) : BP_W'(4);
        data_pos  = byte_pos - hdr_bytes;
        addr_k    = 2'(hdr_bytes - BP_W'(1) - byte_pos);
        last_bit  = CNT_W'((int'(hdr_bytes) + PAGE_BYTES) * 8 - 1);
        rd_idx    = data_pos[IDX_W-1:0];
        if (byte_pos == '0)            cur_byte = FLASH_OP_PROGRAM;
        else if (byte_pos < hdr_bytes) cur_byte = s_q.addr[addr_k];
        else                           cur_byte = rd_byte;
    end

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.phase = 1'b0;
                s_d.cnt   = '0;
                s_d.addr  = addr;
                s_d.wide  = wide;
            end
        end else if (!s_q.phase) begin
            s_d.phase = 1'b1;
        end else begin
            s_d.phase = 1'b0;
            if (s_q.cnt == last_bit) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign cs_n = ~s_q.busy;
    assign sck  = s_q.busy & s_q.phase;
    assign mosi = s_q.busy & cur_byte[3'd7 - s_q.cnt[2:0]];

    // R6: a qualified start always opens a frame
    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !s_q.busy) |=> s_q.busy);
    // R10: a frame only closes after its final bit
    p_end_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> ($past(s_q.cnt) == $past(last_bit)));
    // R11: captured address and width stay fixed during the frame
    p_latched_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> (!s_q.busy || ($stable(s_q.addr) && $stable(s_q.wide))));
    // R7: each bit holds for a low phase then a high phase
    p_bit_pace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.phase) |=> (s_q.phase && $stable(s_q.cnt)));
endmodule

// File: rtl/pp_write_buffer.sv
module pp_write_buffer
    import pp_wb_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int SEL_W     = $clog2(ADDR_REG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_req,
    output logic              mode_ack,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] word_data,
    input  logic              addr_wr,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [7:0]        addr_data,
    input  logic              width_wr,
    input  logic              width_sel,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_code,
    output logic              busy,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi
);
    typedef struct packed {
        logic [ADDR_REG_BYTES-1:0][7:0] addr;
        logic                           wide;
        logic                           req;
        logic                           mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             go;
    logic             enter_prog;
    logic             store_wr;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    assign go       = cmd_wr && (cmd_code == CMD_BUF_PROGRAM) && ctl_q.mode && !busy;
    assign store_wr = word_wr && ctl_q.mode && !busy;

    always_comb begin
        ctl_d = ctl_q;
        if (addr_wr)  ctl_d.addr[addr_sel] = addr_data;
        if (width_wr) ctl_d.wide = width_sel;
        if (mode_wr)  ctl_d.req = mode_req;
        if (!busy && !go) ctl_d.mode = ctl_d.req;
        enter_prog = ctl_d.mode && !ctl_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mode_ack = ctl_q.mode;

    pp_page_store #(.PAGE_BYTES(PAGE_BYTES), .WORD_W(WORD_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_ptr(enter_prog),
        .wr_en    (store_wr),
        .wr_word  (word_data),
        .rd_idx   (rd_idx),
        .rd_byte  (rd_byte)
    );

    pp_serial_seq #(.PAGE_BYTES(PAGE_BYTES)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go),
        .addr   (ctl_q.addr),
        .wide   (ctl_q.wide),
        .rd_byte(rd_byte),
        .rd_idx (rd_idx),
        .busy   (busy),
        .sck    (spi_sck),
        .cs_n   (spi_cs_n),
        .mosi   (spi_mosi)
    );

    // R2: granted mode frozen while a frame runs
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_ack));
    // R2: idle request write shows on readback next clock
    p_mode_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !busy && !go) |=> (mode_ack == $past(mode_req)));
    // R6: program code in prefetch use is refused
    p_refuse_prefetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == CMD_BUF_PROGRAM && !mode_ack && !busy) |=> !busy);
    // R6: other codes never start a frame
    p_refuse_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code != CMD_BUF_PROGRAM && !busy) |=> !busy);
endmodule

// File: tb/pp_write_buffer_tb_top.sv
module pp_write_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE  = 128;
    localparam int WORDS = PAGE / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 0, mode_req = 0, word_wr = 0, addr_wr = 0;
    logic        width_wr = 0, width_sel = 0, cmd_wr = 0;
    logic [31:0] word_data = '0;
    logic [1:0]  addr_sel = '0;
    logic [7:0]  addr_data = '0, cmd_code = '0;
    logic        mode_ack, busy, spi_sck, spi_cs_n, spi_mosi;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_write_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_req(mode_req),
        .mode_ack(mode_ack), .word_wr(word_wr), .word_data(word_data),
        .addr_wr(addr_wr), .addr_sel(addr_sel), .addr_data(addr_data),
        .width_wr(width_wr), .width_sel(width_sel), .cmd_wr(cmd_wr),
        .cmd_code(cmd_code), .busy(busy), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] ref_mem [WORDS];
    int          ref_ptr = 0;
    logic        ref_mode = 0;
    logic [7:0]  ref_addr [4];
    logic        ref_wide = 0;
    logic [7:0]  exp_bytes [0:PAGE+4];
    bit          cap_bits [0:1199];
    int          cap_n = 0;

    always @(negedge clk) begin
        if (!spi_cs_n && spi_sck) begin
            if (cap_n < 1200) cap_bits[cap_n] = spi_mosi;
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(input int i, input int hdr);
        logic [31:0] w;
        if (i == 0) return 8'h02;
        if (i < hdr) return ref_addr[hdr - 1 - i];
        w = ref_mem[(i - hdr) / 4];
        return w[((i - hdr) % 4) * 8 +: 8];
    endfunction

    task automatic set_mode(input logic b);
        mode_wr = 1; mode_req = b;
        @(negedge clk);
        mode_wr = 0;
        if (b && !ref_mode) ref_ptr = 0;
        ref_mode = b;
    endtask

    task automatic put_word(input logic [31:0] w);
        word_wr = 1; word_data = w;
        @(negedge clk);
        word_wr = 0;
        if (ref_mode) begin
            ref_mem[ref_ptr] = w;
            ref_ptr = (ref_ptr + 1) % WORDS;
        end
    endtask

    task automatic set_addr(input logic [31:0] a);
        for (int k = 0; k < 4; k++) begin
            addr_wr = 1; addr_sel = 2'(k); addr_data = a[k*8 +: 8];
            @(negedge clk);
            ref_addr[k] = a[k*8 +: 8];
        end
        addr_wr = 0;
    endtask

    task automatic set_width(input logic b);
        width_wr = 1; width_sel = b;
        @(negedge clk);
        width_wr = 0;
        ref_wide = b;
    endtask

    task automatic issue_cmd(input logic [7:0] code);
        cmd_wr = 1; cmd_code = code;
        @(negedge clk);
        cmd_wr = 0;
    endtask

    task automatic run_program(input string tag, input bit disturb);
        int hdr, nbytes, cnt, mism, first;
        hdr = ref_wide ? 5 : 4;
        nbytes = hdr + PAGE;
        for (int i = 0; i < nbytes; i++) exp_bytes[i] = model_byte(i, hdr);
        cap_n = 0;
        issue_cmd(8'h10);
        check(busy == 1'b1, {tag, " R6 start accepted"}, 32'(busy), 1);
        cnt = 0;
        while (busy && cnt < 4000) begin
            cnt++;
            if (disturb && cnt == 100) begin
                word_wr = 1; word_data = 32'hA5A5_0F0F;
                addr_wr = 1; addr_sel = 2'd0; addr_data = 8'hEE;
                width_wr = 1; width_sel = ~ref_wide;
                mode_wr = 1; mode_req = 1'b0;
            end else if (disturb && cnt == 101) begin
                word_wr = 0; addr_wr = 0; width_wr = 0; mode_wr = 0;
            end
            if (disturb && cnt == 120)
                check(mode_ack == 1'b1, "R2 request held during frame", 32'(mode_ack), 1);
            @(negedge clk);
        end
        check(cnt == 2 * nbytes * 8, {tag, " R10 busy length"}, cnt, 2 * nbytes * 8);
        check(spi_cs_n == 1'b1, {tag, " R10 chip select released"}, 32'(spi_cs_n), 1);
        check(cap_n == nbytes * 8, {tag, " R7 bit count"}, cap_n, nbytes * 8);
        mism = 0; first = -1;
        for (int j = 0; j < nbytes * 8 && j < cap_n; j++) begin
            if (cap_bits[j] != exp_bytes[j / 8][7 - (j % 8)]) begin
                mism++;
                if (first < 0) first = j;
            end
        end
        check(mism == 0, {tag, " R7 R8 R3 frame content, actual=mismatches expected=first bad bit"},
              mism, first);
        if (disturb) begin
            ref_addr[0] = 8'hEE;
            ref_wide = ~ref_wide;
            @(negedge clk);
            check(mode_ack == 1'b0, "R2 held request applied after frame", 32'(mode_ack), 0);
            ref_mode = 0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd31337));
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        for (int k = 0; k < 4; k++) ref_addr[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0, "R1 busy after reset", 32'(busy), 0);
        check(spi_cs_n == 1, "R1 cs_n after reset", 32'(spi_cs_n), 1);
        check(spi_sck == 0, "R1 sck after reset", 32'(spi_sck), 0);
        check(mode_ack == 0, "R1 mode after reset", 32'(mode_ack), 0);

        // R6: program code refused in prefetch use
        issue_cmd(8'h10);
        check(busy == 0, "R6 refused in prefetch use", 32'(busy), 0);
        // R5: words in prefetch use are dropped (model unchanged)
        put_word(32'hDEAD_0001); put_word(32'hDEAD_0002); put_word(32'hDEAD_0003);

        set_mode(1'b1);
        check(mode_ack == 1, "R2 readback after request", 32'(mode_ack), 1);

        // R9 R8 R12: 3-byte address, nothing loaded, page all zero
        set_addr(32'h4C3B_2A19);
        set_width(1'b0);
        run_program("R5 R9 empty page 3-byte", 0);

        // R3: full random page, 4-byte address
        for (int i = 0; i < WORDS; i++) put_word($urandom);
        set_addr($urandom);
        set_width(1'b1);
        run_program("R3 R8 full page 4-byte", 0);

        // R6: wrong code in program use
        issue_cmd(8'h04);
        check(busy == 0, "R6 other code ignored", 32'(busy), 0);

        // R4: 33 words wrap onto word 0
        for (int i = 0; i < WORDS + 1; i++) put_word($urandom);
        run_program("R4 wrap after 32 words", 0);

        // R4 R12: re-entry restarts pointer, partial fill
        set_mode(1'b0);
        check(mode_ack == 0, "R2 readback prefetch", 32'(mode_ack), 0);
        set_mode(1'b1);
        for (int i = 0; i < 5; i++) put_word($urandom);
        set_width(1'b0);
        run_program("R4 R12 partial fill after re-entry", 0);

        // R11 R5 R2: writes during a frame
        run_program("R11 frame with writes during busy", 1);
        set_mode(1'b1);
        run_program("R5 page untouched by busy-time word", 0);

        // random mix
        for (int t = 0; t < 3; t++) begin
            int n;
            n = int'($urandom_range(1, WORDS));
            set_mode(1'b0);
            set_mode(1'b1);
            for (int i = 0; i < n; i++) put_word($urandom);
            set_addr($urandom);
            set_width(1'($urandom_range(0, 1)));
            run_program("R3 R7 R12 random fill", 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule